// File: doc/BRIEF.md
# DMA Completion Interrupt Controller

This block turns end-of-transfer events from ten DMA channels into latched, maskable interrupt requests. Each channel reports a transfer strobe whenever a real data movement decrements its word count. It also reports its current count and a strobe that marks a software write to the count. Channels 6 to 9 serve the external port. In master mode they also carry a second, external count. The block watches these signals and decides when a channel has finished. It then records one pending bit per channel.

The pending bits are qualified by a mask. A fixed-priority picker selects the highest-priority pending channel and drives a request, the channel index and a vector address. An acknowledge carrying a channel index clears that channel's pending bit. Software can also set or clear pending bits directly. Each channel has a chaining-enable bit and a chained-interrupt-enable bit. Together they can suppress completion interrupts while chaining is active.

Top module: `dma_irq_ctrl`

## Requirements
- R1: A channel completes when its transfer strobe is high, its zero condition holds on the presented counts, and the zero condition did not hold in the previous cycle; its pending bit is set at the next clock edge. A channel whose counts already sat at zero does not complete again.
- R2: A count write strobe in the same cycle as a transfer strobe suppresses completion, and a written zero with no transfer never raises a pending bit.
- R3: For channels 6 to 9 with their master-mode bit set, the zero condition needs both the count and the external count at zero; without master mode, and for channels 0 to 5, only the count is looked at and the external count is ignored.
- R4: With chaining enabled and the chained-interrupt-enable bit at 0, a completion sets no pending bit; with chaining disabled, the chained-interrupt-enable bit has no effect.
- R5: `pend_q[i]` is the pending bit of channel i, which stands for interrupt number 10+i; it is readable every cycle.
- R6: `irq_req` is high, combinationally, exactly when some bit of `pend_q & irq_mask` is 1.
- R7: `irq_chan` is the lowest channel index among masked pending bits (channel 0 highest priority, channel 9 lowest), and 0 when there is no request.
- R8: At each edge where `irq_req` is high, `irq_vec` loads base + 4*(10+`irq_chan`), with base 0x0002_0000 when `vec_ext` is 0 and 0x0040_0000 when it is 1. It holds its value while `irq_req` is low.
- R9: `ack_valid` with `ack_idx` equal to a channel index clears that channel's pending bit at the next edge. Indices of 10 or more do nothing.
- R10: `sw_set[i]` sets and `sw_clr[i]` clears pending bit i. A completion or a software set in the same cycle as any clear of the same bit leaves the bit set.
- R11: After reset, `pend_q` is 0, `irq_req` is 0 and `irq_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_stb | input | 10 | Per channel: a transfer decremented the count this cycle |
| cnt_wr | input | 10 | Per channel: software wrote the count this cycle |
| cnt_flat | input | 160 | Per channel count, channel i at bits [16i+15:16i] |
| ecnt_flat | input | 64 | External count of channels 6..9, channel 6+j at [16j+15:16j] |
| master_mode | input | 4 | Master-mode bit of channels 6..9 |
| chain_en | input | 10 | Per channel chaining enable |
| chain_irq_en | input | 10 | Per channel chained-interrupt enable |
| irq_mask | input | 10 | Per channel interrupt mask, 1 = enabled |
| sw_set | input | 10 | Software set of pending bits |
| sw_clr | input | 10 | Software clear of pending bits |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | 4 | Channel index being acknowledged |
| vec_ext | input | 1 | Vector table location: 0 internal, 1 external |
| pend_q | output | 10 | Pending bits |
| irq_req | output | 1 | Interrupt request |
| irq_chan | output | 4 | Selected channel index |
| irq_vec | output | 32 | Registered vector address |

## Verification
A corrupted zero-history flop shows up as a missing or extra pending bit, visible on `pend_q` one edge after the strobe that should or should not have completed. A pending bit set or cleared by mistake changes `irq_req` and `irq_chan` at once, and `irq_vec` changes one edge later. The stimulus drives small counts so that decrements to zero, re-strobes at zero, writes of zero and master-mode pairs occur often. Every output is compared on every cycle, so any divergence shows within one cycle of its cause.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam logic [31:0] VEC_BASE_INT = 32'h0002_0000;
  localparam logic [31:0] VEC_BASE_EXT = 32'h0040_0000;
  localparam int unsigned VEC_STRIDE   = 4;

  // Vector address for a given interrupt bit number and table location.
  function automatic logic [31:0] f_vec_addr(input logic ext, input int unsigned bitnum);
    logic [31:0] base;
    base = ext ? VEC_BASE_EXT : VEC_BASE_INT;
    return base + 32'(bitnum * VEC_STRIDE);
  endfunction
endpackage

// File: rtl/dma_done_detect.sv
module dma_done_detect #(
  parameter int CNT_W   = 16,
  parameter bit HAS_EXT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_stb,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] ecnt,
  input  logic             master,
  input  logic             chain_en,
  input  logic             chain_irq_en,
  output logic             done
);
  // Zero condition of this channel's counters.
  function automatic logic f_at_zero(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] e,
                                     input logic m);
    logic need_ext;
    need_ext = HAS_EXT && m;
    return (c == '0) && (!need_ext || (e == '0));
  endfunction

  logic zero_now;
  logic zero_prev;
  logic armed;
  logic gate_ok;

  assign zero_now = f_at_zero(cnt, ecnt, master);
  assign armed    = !zero_prev;
  assign gate_ok  = !chain_en || chain_irq_en;
  assign done     = xfer_stb && !cnt_wr && zero_now && armed && gate_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) zero_prev <= 1'b1;
    else        zero_prev <= zero_now;
  end

  // R2: a count write never produces a completion
  p_wr_no_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> !done);
  // R1: no completion while the counts were already at zero
  p_no_retrigger_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(rst_n)) |-> !$past(zero_now));
  // R4: chaining with the interrupt enable off blocks completion
  p_chain_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && !chain_irq_en) |-> !done);
endmodule

// File: rtl/dma_irq_latch.sv
module dma_irq_latch #(
  parameter int NCH   = 10,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   done,
  input  logic [NCH-1:0]   sw_set,
  input  logic [NCH-1:0]   sw_clr,
  input  logic             ack_valid,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [NCH-1:0]   pend_q
);
  logic [NCH-1:0] ack_hit;
  logic [NCH-1:0] set_v;
  logic [NCH-1:0] clr_v;
  logic [NCH-1:0] pend_d;

  // One-hot decode of the acknowledge; out-of-range indices hit nothing.
  function automatic logic [NCH-1:0] f_ack_decode(input logic v, input logic [IDX_W-1:0] idx);
    logic [NCH-1:0] r;
    r = '0;
    for (int k = 0; k < NCH; k++) r[k] = v && (idx == IDX_W'(k));
    return r;
  endfunction

  assign ack_hit = f_ack_decode(ack_valid, ack_idx);
  assign set_v   = done | sw_set;
  assign clr_v   = sw_clr | ack_hit;
  assign pend_d  = set_v | (pend_q & ~clr_v);

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R10: any set wins over a clear in the same cycle
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[g] |=> pend_q[g]);
    // R9: an acknowledge with no set clears the bit
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit[g] && !set_v[g]) |=> !pend_q[g]);
  end
endmodule

// File: rtl/dma_irq_prio.sv
module dma_irq_prio #(
  parameter int NCH      = 10,
  parameter int BIT_BASE = 10,
  parameter int IDX_W    = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   pend,
  input  logic [NCH-1:0]   mask,
  input  logic             vec_ext,
  output logic             irq_req,
  output logic [IDX_W-1:0] irq_chan,
  output logic [31:0]      irq_vec
);
  logic [NCH-1:0] live;

  // Lowest set index wins.
  function automatic logic [IDX_W-1:0] f_pick(input logic [NCH-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = NCH - 1; k >= 0; k--) if (v[k]) r = IDX_W'(k);
    return r;
  endfunction

  assign live     = pend & mask;
  assign irq_req  = |live;
  assign irq_chan = f_pick(live);

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_vec <= '0;
    else if (irq_req) irq_vec <= dma_irq_pkg::f_vec_addr(vec_ext, BIT_BASE + int'(irq_chan));
  end

  // R7: the selected channel is pending and enabled
  p_chan_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend[irq_chan] && mask[irq_chan]));
  // R8: the vector holds while nothing is requested
  p_vec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && $past(rst_n)) |=> $stable(irq_vec));
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int NCH       = 10,
  parameter int CNT_W     = 16,
  parameter int EXT_FIRST = 6,
  parameter int BIT_BASE  = 10,
  localparam int NEXT     = NCH - EXT_FIRST,
  localparam int IDX_W    = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       xfer_stb,
  input  logic [NCH-1:0]       cnt_wr,
  input  logic [NCH*CNT_W-1:0] cnt_flat,
  input  logic [NEXT*CNT_W-1:0] ecnt_flat,
  input  logic [NEXT-1:0]      master_mode,
  input  logic [NCH-1:0]       chain_en,
  input  logic [NCH-1:0]       chain_irq_en,
  input  logic [NCH-1:0]       irq_mask,
  input  logic [NCH-1:0]       sw_set,
  input  logic [NCH-1:0]       sw_clr,
  input  logic                 ack_valid,
  input  logic [IDX_W-1:0]     ack_idx,
  input  logic                 vec_ext,
  output logic [NCH-1:0]       pend_q,
  output logic                 irq_req,
  output logic [IDX_W-1:0]     irq_chan,
  output logic [31:0]          irq_vec
);
  logic [NCH-1:0] done;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i >= EXT_FIRST) begin : g_ext
      dma_done_detect #(.CNT_W(CNT_W), .HAS_EXT(1'b1)) u_det (
        .clk(clk), .rst_n(rst_n), .xfer_stb(xfer_stb[i]), .cnt_wr(cnt_wr[i]),
        .cnt(cnt_flat[i*CNT_W +: CNT_W]),
        .ecnt(ecnt_flat[(i-EXT_FIRST)*CNT_W +: CNT_W]),
        .master(master_mode[i-EXT_FIRST]),
        .chain_en(chain_en[i]), .chain_irq_en(chain_irq_en[i]), .done(done[i]));
    end else begin : g_int
      dma_done_detect #(.CNT_W(CNT_W), .HAS_EXT(1'b0)) u_det (
        .clk(clk), .rst_n(rst_n), .xfer_stb(xfer_stb[i]), .cnt_wr(cnt_wr[i]),
        .cnt(cnt_flat[i*CNT_W +: CNT_W]), .ecnt('0), .master(1'b0),
        .chain_en(chain_en[i]), .chain_irq_en(chain_irq_en[i]), .done(done[i]));
    end
  end

  dma_irq_latch #(.NCH(NCH), .IDX_W(IDX_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .done(done), .sw_set(sw_set), .sw_clr(sw_clr),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .pend_q(pend_q));

  dma_irq_prio #(.NCH(NCH), .BIT_BASE(BIT_BASE), .IDX_W(IDX_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .pend(pend_q), .mask(irq_mask), .vec_ext(vec_ext),
    .irq_req(irq_req), .irq_chan(irq_chan), .irq_vec(irq_vec));

  // R6: a request exists only with a pending bit behind it
  p_req_has_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend_q != '0));
  // R5: every completion becomes a pending bit
  p_done_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done != '0) |=> ((pend_q & $past(done)) == $past(done)));
endmodule

// File: tb/dma_irq_ctrl_bench.sv
module dma_irq_ctrl_bench;
  localparam int NCH = 10, W = 16, EF = 6, NX = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] xfer_stb = '0, cnt_wr = '0, chain_en = '0, chain_irq_en = '0;
  logic [NCH-1:0] irq_mask = '0, sw_set = '0, sw_clr = '0;
  logic [NCH*W-1:0] cnt_flat;
  logic [NX*W-1:0] ecnt_flat;
  logic [NX-1:0] master_mode = '0;
  logic ack_valid = 1'b0, vec_ext = 1'b0;
  logic [3:0] ack_idx = '0;
  logic [NCH-1:0] pend_q;
  logic irq_req;
  logic [3:0] irq_chan;
  logic [31:0] irq_vec;

  int cnt [NCH];
  int ecnt[NX];
  int n_tests = 0, n_fail = 0;
  logic [NCH-1:0] m_pend = '0, m_zp = '1;
  logic [31:0] m_vec = '0;

  always #5 clk = ~clk;

  dma_irq_ctrl u_dma_irq_ctrl (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit m_zero(input int i);
    if (cnt[i] != 0) return 1'b0;
    if (i >= EF && master_mode[i-EF]) return ecnt[i-EF] == 0;
    return 1'b1;
  endfunction

  function automatic int m_pick(input logic [NCH-1:0] v);
    int k = 0;
    while (k < NCH && !v[k]) k++;
    return (k < NCH) ? k : 0;
  endfunction

  function automatic logic [31:0] m_addr(input logic ext, input int ch);
    return (ext ? 32'h0040_0000 : 32'h0002_0000) + 32'(40 + 4 * ch);
  endfunction

  task automatic step();
    logic [NCH-1:0] nz, nd, npend, live;
    logic [31:0] nvec;
    for (int i = 0; i < NCH; i++) cnt_flat[i*W +: W] = W'(cnt[i]);
    for (int j = 0; j < NX; j++) ecnt_flat[j*W +: W] = W'(ecnt[j]);
    for (int i = 0; i < NCH; i++) begin
      nz[i] = m_zero(i);
      nd[i] = xfer_stb[i] && !cnt_wr[i] && nz[i] && !m_zp[i] && (!chain_en[i] || chain_irq_en[i]);
    end
    npend = m_pend;
    for (int i = 0; i < NCH; i++) begin
      if (sw_clr[i] || (ack_valid && ack_idx == 4'(i))) npend[i] = 1'b0;
      if (nd[i] || sw_set[i]) npend[i] = 1'b1;
    end
    live = m_pend & irq_mask;
    nvec = (live != 0) ? m_addr(vec_ext, m_pick(live)) : m_vec;
    @(posedge clk);
    m_pend = npend; m_zp = nz; m_vec = nvec;
    @(negedge clk);
    live = m_pend & irq_mask;
    chk("R5 pend", 32'(pend_q), 32'(m_pend));
    chk("R6 req", 32'(irq_req), 32'(live != 0));
    chk("R7 chan", 32'(irq_chan), 32'(m_pick(live)));
    chk("R8 vec", irq_vec, m_vec);
    xfer_stb = '0; cnt_wr = '0; sw_set = '0; sw_clr = '0; ack_valid = 1'b0;
  endtask

  task automatic dec(input int i);
    xfer_stb[i] = 1'b1;
    if (cnt[i] > 0) cnt[i]--;
    else if (i >= EF && ecnt[i-EF] > 0) ecnt[i-EF]--;
  endtask

  task automatic ack(input int i);
    ack_valid = 1'b1; ack_idx = 4'(i); step();
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NCH; i++) cnt[i] = 0;
    for (int j = 0; j < NX; j++) ecnt[j] = 0;
    for (int i = 0; i < NCH; i++) cnt_flat[i*W +: W] = '0;
    ecnt_flat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R11 reset pend", 32'(pend_q), 0);
    chk("R11 reset req", 32'(irq_req), 0);
    chk("R11 reset vec", irq_vec, 0);
    irq_mask = '1;

    // R1: decrement to zero completes; a strobe at zero does not again
    cnt[0] = 2; cnt_wr[0] = 1'b1; step();
    dec(0); step(); dec(0); step();
    chk("R1 done ch0", 32'(pend_q[0]), 1);
    ack(0);
    chk("R9 ack clears ch0", 32'(pend_q[0]), 0);
    dec(0); step();
    chk("R1 no retrigger ch0", 32'(pend_q[0]), 0);

    // R2: write of zero alongside a transfer does nothing
    cnt[1] = 1; cnt_wr[1] = 1'b1; step();
    cnt[1] = 0; cnt_wr[1] = 1'b1; xfer_stb[1] = 1'b1; step();
    chk("R2 write zero ch1", 32'(pend_q[1]), 0);

    // R3: master mode waits for both counters
    master_mode[0] = 1'b1; cnt[6] = 1; ecnt[0] = 1; cnt_wr[6] = 1'b1; step();
    dec(6); step();
    chk("R3 master half ch6", 32'(pend_q[6]), 0);
    dec(6); step();
    chk("R3 master both ch6", 32'(pend_q[6]), 1);
    cnt[7] = 1; ecnt[1] = 5; cnt_wr[7] = 1'b1; step();
    dec(7); step();
    chk("R3 non-master ch7", 32'(pend_q[7]), 1);
    ack(6); ack(7);

    // R4: chaining gate
    chain_en[3] = 1'b1; chain_irq_en[3] = 1'b0; cnt[3] = 1; cnt_wr[3] = 1'b1; step();
    dec(3); step();
    chk("R4 chain blocks ch3", 32'(pend_q[3]), 0);
    chain_en[3] = 1'b0; cnt[3] = 1; cnt_wr[3] = 1'b1; step();
    dec(3); step();
    chk("R4 enable ignored ch3", 32'(pend_q[3]), 1);
    ack(3);

    // R7 / R8: priority and vectors
    sw_set[4] = 1'b1; sw_set[9] = 1'b1; step();
    chk("R7 picks ch4", 32'(irq_chan), 4);
    step();
    chk("R8 vec ch4 int", irq_vec, 32'h0002_0038);
    irq_mask[4] = 1'b0; vec_ext = 1'b1; step(); step();
    chk("R7 picks ch9", 32'(irq_chan), 9);
    chk("R8 vec ch9 ext", irq_vec, 32'h0040_004C);
    irq_mask = '0; step();
    chk("R6 masked no req", 32'(irq_req), 0);
    irq_mask = '1; vec_ext = 1'b0;
    ack(12);
    chk("R9 bad index ignored", 32'(pend_q), 32'h210);

    // R10: completion beats a clear in the same cycle
    sw_clr = '1; step();
    cnt[2] = 1; cnt_wr[2] = 1'b1; step();
    dec(2); sw_clr[2] = 1'b1; step();
    chk("R10 done beats clear ch2", 32'(pend_q[2]), 1);
    sw_set[5] = 1'b1; ack_valid = 1'b1; ack_idx = 4'd5; step();
    chk("R10 set beats ack ch5", 32'(pend_q[5]), 1);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 50 == 0) irq_mask = NCH'($urandom);
      if ($urandom % 60 == 0) begin chain_en = NCH'($urandom); chain_irq_en = NCH'($urandom); end
      if ($urandom % 80 == 0) master_mode = NX'($urandom);
      if ($urandom % 40 == 0) vec_ext = 1'($urandom);
      for (int i = 0; i < NCH; i++) begin
        int r = $urandom % 16;
        if (r < 5) dec(i);
        else if (r == 5) begin
          cnt_wr[i] = 1'b1; cnt[i] = $urandom % 4;
          if (i >= EF) ecnt[i-EF] = $urandom % 3;
          if ($urandom % 3 == 0) xfer_stb[i] = 1'b1;
        end
      end
      if ($urandom % 5 == 0) begin ack_valid = 1'b1; ack_idx = 4'($urandom % 12); end
      if ($urandom % 30 == 0) sw_set = NCH'($urandom) & NCH'($urandom);
      if ($urandom % 30 == 0) sw_clr = NCH'($urandom);
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule